// File: doc/BRIEF.md
# Serial-Entry Shift Register with Set/Clear/Toggle First Stage

This block is a small register of `WIDTH` stages (four by default) that either shifts its contents one stage toward the last stage or captures a parallel word. A single mode input picks between the two on every rising clock edge. In shift mode the first stage does not simply take a serial bit. It takes its next value from a pair of entry inputs: a positive J input and an active-low K input. Together they can force the stage high, force it low, invert it or leave it as it is.

Tying the two entry inputs together turns the first stage into an ordinary serial data input. Wiring each stage output back to the parallel input one position lower, while holding load mode, moves the data toward the first stage instead. An active-low master reset clears every stage at once, without waiting for the clock. Besides the stage values, the block drives the inverted value of the last stage.

Top module: `jk_shift_reg`

## Requirements
- R1: With `modeShift` high, each rising edge moves stage i-1 into stage i for every i from 1 to WIDTH-1 (`qOut[0]` is the first stage).
- R2: With `modeShift` low, each rising edge copies `parIn[i]` into `qOut[i]` for every stage.
- R3: In shift mode, `jIn`=1 with `kInN`=1 sets the first stage to 1.
- R4: In shift mode, `jIn`=0 with `kInN`=0 clears the first stage to 0.
- R5: In shift mode, `jIn`=1 with `kInN`=0 inverts the first stage.
- R6: In shift mode, `jIn`=0 with `kInN`=1 keeps the first stage at its previous value.
- R7: With `jIn` and `kInN` driven by the same bit, shift mode enters that bit into the first stage, like a plain D input.
- R8: `rstN` low clears all stages immediately, with no clock edge needed.
- R9: While `rstN` stays low, clock edges leave all stages at 0, whatever the other inputs are.
- R10: `lastN` always equals the inverse of the last stage `qOut[WIDTH-1]`.
- R11: With `parIn[i-1]` wired to `qOut[i]` and `modeShift` low, each edge moves the data one stage toward stage 0, and `parIn[WIDTH-1]` fills the last stage.
- R12: Changes on `modeShift`, `jIn`, `kInN` or `parIn` between clock edges have no effect on `qOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all loads and shifts occur on its rising edge |
| rstN | input | 1 | Asynchronous master clear, active low |
| modeShift | input | 1 | 1 = shift toward the last stage, 0 = parallel load |
| jIn | input | 1 | First-stage entry input, active high |
| kInN | input | 1 | First-stage entry input, active low |
| parIn | input | WIDTH | Parallel data, bit i feeds stage i |
| qOut | output | WIDTH | Stage values, bit 0 is the first stage |
| lastN | output | 1 | Inverse of the last stage |

## Verification
The bench applies all four entry combinations and repeats the invert case with the first stage at both 0 and 1. A design that swapped the hold and invert codes, or treated `kInN` as active high, would give the wrong first stage while the upper stages still looked correct. Reset is asserted halfway between edges and held across edges while load mode presents all ones. A synchronous reset, or one that yields to the load, would leave ones in the stages. The shift-left wiring and the D-tied entry are both exercised, which catches a reversed stage order. Inputs are also toggled between edges to expose a level-sensitive capture.

// File: rtl/jk_shift_pkg.sv
package jk_shift_pkg;

  // Strobes passed from the entry/mode control to the stage datapath
  typedef struct packed {
    logic shiftSel;   // 1: shift toward last stage, 0: parallel load
    logic firstNext;  // next value for stage 0 when shifting
  } shiftStrobes_t;

endpackage

// File: rtl/jk_shift_ctrl.sv
module jk_shift_ctrl
  import jk_shift_pkg::*;
(
  input  logic          modeShift,
  input  logic          jIn,
  input  logic          kInN,
  input  logic          firstQ,
  output shiftStrobes_t strobes
);

  logic entryNext;

  // Entry decode: {J, K_n} = 00 clear, 01 hold, 10 invert, 11 set
  always_comb begin
    unique case ({jIn, kInN})
      2'b00:   entryNext = 1'b0;
      2'b01:   entryNext = firstQ;
      2'b10:   entryNext = ~firstQ;
      default: entryNext = 1'b1;
    endcase
  end

  always_comb begin
    strobes.shiftSel  = modeShift;
    strobes.firstNext = entryNext;
  end

endmodule

// File: rtl/jk_shift_path.sv
module jk_shift_path
  import jk_shift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  shiftStrobes_t    strobes,
  input  logic [WIDTH-1:0] parIn,
  input  logic             modeShift,
  input  logic             jIn,
  input  logic             kInN,
  output logic [WIDTH-1:0] qOut
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] stageNext;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign stageNext[i] = strobes.shiftSel ? strobes.firstNext : parIn[i];
      end else begin : g_rest
        assign stageNext[i] = strobes.shiftSel ? qOut[i-1] : parIn[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) qOut <= '0;
    else       qOut <= stageNext;
  end

  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!rstN)
    !modeShift |=> qOut == $past(parIn));  // R2

  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rstN)
    modeShift |=> qOut[LAST:1] == $past(qOut[LAST-1:0]));  // R1

  AST_ENTRY_SET: assert property (@(posedge clk) disable iff (!rstN)
    (modeShift && jIn && kInN) |=> qOut[0]);  // R3

  AST_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (modeShift && !jIn && !kInN) |=> !qOut[0]);  // R4

  AST_ENTRY_INVERT: assert property (@(posedge clk) disable iff (!rstN)
    (modeShift && jIn && !kInN) |=> qOut[0] != $past(qOut[0]));  // R5

  AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (modeShift && !jIn && kInN) |=> $stable(qOut[0]));  // R6

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |-> qOut == '0);  // R9

endmodule

// File: rtl/jk_shift_reg.sv
module jk_shift_reg
  import jk_shift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeShift,
  input  logic             jIn,
  input  logic             kInN,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] qOut,
  output logic             lastN
);

  shiftStrobes_t strobes;

  jk_shift_ctrl i_ctrl (
    .modeShift (modeShift),
    .jIn       (jIn),
    .kInN      (kInN),
    .firstQ    (qOut[0]),
    .strobes   (strobes)
  );

  jk_shift_path #(.WIDTH(WIDTH)) i_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .parIn     (parIn),
    .modeShift (modeShift),
    .jIn       (jIn),
    .kInN      (kInN),
    .qOut      (qOut)
  );

  // R10: inverted last stage
  assign lastN = ~qOut[WIDTH-1];

endmodule

// File: tb/test_jk_shift_reg.sv
module test_jk_shift_reg;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeShift = 1'b0;
  logic       jIn = 1'b0;
  logic       kInN = 1'b0;
  logic [3:0] parDrv = 4'h0;
  logic       leftMode = 1'b0;
  logic       leftIn = 1'b0;
  logic [3:0] parIn;
  logic [3:0] qOut;
  logic       lastN;

  int vecCount  = 0;
  int missCount = 0;
  bit finished  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  // External shift-left wiring: stage i feeds parallel input i-1
  assign parIn = leftMode ? {leftIn, qOut[3:1]} : parDrv;

  jk_shift_reg #(.WIDTH(4)) i_jk_shift_reg (
    .clk       (clk),
    .rstN      (rstN),
    .modeShift (modeShift),
    .jIn       (jIn),
    .kInN      (kInN),
    .parIn     (parIn),
    .qOut      (qOut),
    .lastN     (lastN)
  );

  // Vector: {modeShift, jIn, kInN, parIn[3:0], expected qOut[3:0]}
  localparam int NVEC = 12;
  localparam logic [10:0] VECS [NVEC] = '{
    {3'b000, 4'b1010, 4'b1010},  // load
    {3'b111, 4'b0000, 4'b0101},  // set
    {3'b100, 4'b0000, 4'b1010},  // clear
    {3'b110, 4'b0000, 4'b0101},  // invert 0->1
    {3'b110, 4'b0000, 4'b1010},  // invert 1->0
    {3'b101, 4'b0000, 4'b0100},  // hold 0
    {3'b000, 4'b0111, 4'b0111},  // load
    {3'b101, 4'b0000, 4'b1111},  // hold 1
    {3'b100, 4'b0000, 4'b1110},  // clear
    {3'b110, 4'b0000, 4'b1101},  // invert
    {3'b000, 4'b0000, 4'b0000},  // load zero
    {3'b111, 4'b0000, 4'b0001}   // set
  };

  function automatic string reqName(input logic [2:0] ctl);
    if (!ctl[2])            return "R2";
    else if (ctl[1:0] == 2'b11) return "R3";
    else if (ctl[1:0] == 2'b00) return "R4";
    else if (ctl[1:0] == 2'b10) return "R5";
    else                    return "R6";
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s: qOut=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkLast(input logic act, input logic exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL R10: lastN=%b expected=%b at %0t", act, exp, $time);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  endtask

  task automatic edgeThenSettle();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #100000;
    missCount++;
    $display("FAIL watchdog: run did not complete");
    finish();
  end

  initial begin
    // Reset state
    #6;
    check("R8", qOut, 4'b0000);
    checkLast(lastN, 1'b1);
    @(negedge clk);
    rstN = 1'b1;

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      {modeShift, jIn, kInN} = VECS[v][10:8];
      parDrv = VECS[v][7:4];
      edgeThenSettle();
      check(reqName(VECS[v][10:8]), qOut, VECS[v][3:0]);
      if (modeShift) check("R1", qOut[3:1], {1'b0, 3'b000} | qOut[3:1]);
      checkLast(lastN, ~VECS[v][3]);
    end

    // R1: upper stages follow lower ones (known state 0001)
    modeShift = 1'b1; jIn = 1'b0; kInN = 1'b1;
    edgeThenSettle();
    check("R1", qOut, 4'b0011);
    edgeThenSettle();
    check("R1", qOut, 4'b0111);

    // R7: entry inputs tied together act as D
    modeShift = 1'b0; parDrv = 4'b0000;
    edgeThenSettle();
    modeShift = 1'b1;
    begin
      logic [3:0] bits = 4'b1101;
      logic [3:0] expQ = 4'b0000;
      for (int b = 3; b >= 0; b--) begin
        jIn = bits[b]; kInN = bits[b];
        expQ = {expQ[2:0], bits[b]};
        edgeThenSettle();
        check("R7", qOut, expQ);
      end
    end

    // R12: input activity between edges does not disturb stages
    #1;
    modeShift = 1'b0; parDrv = 4'b0110; #1;
    jIn = 1'b0; kInN = 1'b0; parDrv = 4'b1001; #1;
    check("R12", qOut, 4'b1101);
    modeShift = 1'b1; jIn = 1'b1; kInN = 1'b1;
    edgeThenSettle();
    check("R12", qOut, 4'b1011);

    // R8: reset in mid-cycle clears without an edge
    @(negedge clk);
    modeShift = 1'b0; parDrv = 4'b1111;
    rstN = 1'b0;
    #1;
    check("R8", qOut, 4'b0000);
    checkLast(lastN, 1'b1);

    // R9: held reset overrides load edges
    edgeThenSettle();
    check("R9", qOut, 4'b0000);
    edgeThenSettle();
    check("R9", qOut, 4'b0000);
    @(negedge clk);
    rstN = 1'b1;
    edgeThenSettle();
    check("R2", qOut, 4'b1111);

    // R11: shift-left through external wiring
    parDrv = 4'b1000;
    edgeThenSettle();
    check("R2", qOut, 4'b1000);
    leftMode = 1'b1; leftIn = 1'b0;
    edgeThenSettle();
    check("R11", qOut, 4'b0100);
    edgeThenSettle();
    check("R11", qOut, 4'b0010);
    edgeThenSettle();
    check("R11", qOut, 4'b0001);
    checkLast(lastN, 1'b1);
    leftIn = 1'b1;
    edgeThenSettle();
    check("R11", qOut, 4'b1000);
    checkLast(lastN, 1'b0);
    leftMode = 1'b0;

    finish();
  end

endmodule